// File: doc/BRIEF.md
# Artifact Blanking and Re-arm Gate

This block decides, cycle by cycle, whether an R-wave detection from an upstream detector may be accepted. Three artifact sources each open their own blanking window: a pacing marker, a shock marker (or overload indication) and electrosurgery activity. Once every window has run out, the gate waits in a recovering phase until the front end is out of overload, noise and baseline are stable and the detection threshold has settled. It then enforces a programmable minimum holdoff before it arms. A separate permission level from the safety interlock can veto acceptance at any time.

The outputs are:
- the Detect-Allowed level;
- a qualified detect strobe;
- a live reason code;
- a mark strobe that records the reason seen by every raw detect, accepted or not;
- a saturating count of suppressed detects.

Window lengths and the holdoff are programmable values held outside the block. One adaptive rule applies: the shock window pauses while overload persists, which extends it.

Top module: `sync_blank_gate`

## Requirements
- R1: After reset the gate is in the recovering phase with `det_allowed` at 0. `reason` reads 4 (recovering) while `ovl_flag` is high.
- R2: Each artifact input loads only its own window timer with its own length L. A trigger sampled at edge k keeps `det_allowed` low through edge k+L+H+2, where H is `min_hold`, provided all qualifiers are good.
- R3: At least H+1 cycles pass in the re-arm phase before detection is allowed. With qualifiers becoming good at edge a, `det_allowed` first reads 1 after edge a+H+1.
- R4: The sequence after a disturbance is blank, recover, re-arm and then armed. `det_allowed` is never 1 while any blanking window is active.
- R5: The recovering phase ends only with `ovl_flag`=0, `noise_ok`=1 and `thresh_ok`=1. `reason` is 5 (threshold unstable) when only the threshold is bad, and otherwise 4.
- R6: With `SHOCK_STRETCH`=1, the shock window timer does not count down on cycles where `ovl_flag` is high, so each such cycle adds one cycle of blanking.
- R7: Reason codes for active windows are 2 (shock), 1 (pace) and 3 (electrosurgery). When windows overlap, the code reported follows the priority shock, then pace, then electrosurgery.
- R8: An artifact trigger arriving in any state restarts that window from its full length and returns the gate to blanking.
- R9: In the armed state, the loss of any qualifier drops `det_allowed` in the same cycle. The gate then has to pass re-arm again (H+2 cycles after the qualifiers recover).
- R10: `lock_inhibit`=1 forces `det_allowed` to 0 and `reason` to 6, with precedence over every other reason. Releasing it in the armed state restores `det_allowed` at once.
- R11: `det_qual` pulses one cycle after a `raw_det` that saw `det_allowed`=1, and never otherwise.
- R12: `mark_stb` pulses one cycle after every `raw_det`, with `mark_reason` holding the `reason` of that cycle. Code 0 means accepted.
- R13: A `raw_det` seen while `det_allowed`=0 increments `supp_cnt` on the next cycle. The count saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pace_evt | input | 1 | Pacing artifact trigger |
| shock_evt | input | 1 | Shock or overload artifact trigger |
| surg_evt | input | 1 | Electrosurgery activity trigger |
| ovl_flag | input | 1 | Front-end overload or clamp conducting |
| noise_ok | input | 1 | Noise floor and baseline stable |
| thresh_ok | input | 1 | Detection threshold stable |
| lock_inhibit | input | 1 | Interlock veto of detection |
| raw_det | input | 1 | Raw R-wave detect strobe |
| pace_len | input | TW | Pacing window length in cycles |
| shock_len | input | TW | Shock window length in cycles |
| surg_len | input | TW | Electrosurgery window length in cycles |
| min_hold | input | TW | Minimum re-arm holdoff in cycles |
| det_allowed | output | 1 | Detect-Allowed level |
| det_qual | output | 1 | Qualified detect strobe |
| reason | output | 3 | Live gating reason code |
| mark_stb | output | 1 | Event mark strobe, one per raw detect |
| mark_reason | output | 3 | Reason captured with the last mark |
| supp_cnt | output | CW | Saturating count of suppressed detects |

## Verification
The assertions assume the following about the inputs:
- `raw_det` is a single-cycle strobe.
- The window lengths and `min_hold` stay constant while a window or holdoff is running.

The stimulus applies each strobe for exactly one cycle and spaces detects at least two cycles apart. It changes the lengths only while the gate is idle, and it always drives the inputs on the falling edge.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

   typedef enum logic [1:0] {
      ST_BLANK   = 2'd0,
      ST_RECOVER = 2'd1,
      ST_REARM   = 2'd2,
      ST_ARMED   = 2'd3
   } gate_state_t;

   typedef enum logic [2:0] {
      RSN_OK     = 3'd0,
      RSN_PACE   = 3'd1,
      RSN_SHOCK  = 3'd2,
      RSN_SURG   = 3'd3,
      RSN_RECOV  = 3'd4,
      RSN_THRESH = 3'd5,
      RSN_LOCK   = 3'd6
   } gate_reason_t;

   localparam int unsigned NUM_WIN = 3;
   localparam int unsigned WIN_PACE  = 0;
   localparam int unsigned WIN_SHOCK = 1;
   localparam int unsigned WIN_SURG  = 2;

endpackage

// File: rtl/blank_timer.sv
module blank_timer #(
   parameter int unsigned TW          = 8,
   parameter bit          HOLD_ON_OVL = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          trig,
   input  logic          freeze,
   input  logic [TW-1:0] len,
   output logic          busy
);

   localparam logic [TW-1:0] ZERO = '0;

   logic [TW-1:0] cnt;
   logic          stall;

   assign stall = freeze & HOLD_ON_OVL;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= ZERO;
      end else if (trig) begin
         cnt <= len;
      end else if (cnt != ZERO && !stall) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign busy = (cnt != ZERO) | trig;

   // An expired window stays expired until a new trigger arrives (R2)
   assert_idle_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy) |=> (busy == trig));

endmodule

// File: rtl/gate_fsm.sv
module gate_fsm
   import sbg_pkg::*;
#(
   parameter int unsigned TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          any_trig,
   input  logic          blank_busy,
   input  logic          quals_ok,
   input  logic [TW-1:0] min_hold,
   output gate_state_t   state
);

   localparam logic [TW-1:0] ZERO = '0;

   logic [TW-1:0] hold;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_RECOVER;
         hold  <= ZERO;
      end else if (any_trig) begin
         state <= ST_BLANK;
      end else begin
         unique case (state)
            ST_BLANK: begin
               if (!blank_busy) state <= ST_RECOVER;
            end
            ST_RECOVER: begin
               if (quals_ok) begin
                  state <= ST_REARM;
                  hold  <= min_hold;
               end
            end
            ST_REARM: begin
               if (!quals_ok)         state <= ST_RECOVER;
               else if (hold == ZERO) state <= ST_ARMED;
               else                   hold  <= hold - 1'b1;
            end
            default: begin
               if (!quals_ok) state <= ST_RECOVER;
            end
         endcase
      end
   end

   // Arming is reachable only through re-arm (R3, R4)
   assert_armed_via_rearm_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ARMED) |-> ($past(state) == ST_REARM || $past(state) == ST_ARMED));

   // The holdoff counter must run out before arming (R3)
   assert_hold_respected_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_REARM && hold != ZERO) |=> (state != ST_ARMED));

   // Leaving recovery needs all qualifiers (R5)
   assert_recover_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_RECOVER && state == ST_REARM) |-> $past(quals_ok));

endmodule

// File: rtl/sync_blank_gate.sv
module sync_blank_gate
   import sbg_pkg::*;
#(
   parameter int unsigned TW            = 8,
   parameter int unsigned CW            = 8,
   parameter bit          SHOCK_STRETCH = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pace_evt,
   input  logic          shock_evt,
   input  logic          surg_evt,
   input  logic          ovl_flag,
   input  logic          noise_ok,
   input  logic          thresh_ok,
   input  logic          lock_inhibit,
   input  logic          raw_det,
   input  logic [TW-1:0] pace_len,
   input  logic [TW-1:0] shock_len,
   input  logic [TW-1:0] surg_len,
   input  logic [TW-1:0] min_hold,
   output logic          det_allowed,
   output logic          det_qual,
   output logic [2:0]    reason,
   output logic          mark_stb,
   output logic [2:0]    mark_reason,
   output logic [CW-1:0] supp_cnt
);

   localparam logic [CW-1:0] CNT_MAX = '1;

   generate
      if (TW < 2) begin : g_bad_tw
         $error("sync_blank_gate: TW must be at least 2");
      end
      if (CW < 1) begin : g_bad_cw
         $error("sync_blank_gate: CW must be at least 1");
      end
   endgenerate

   logic [NUM_WIN-1:0] trig;
   logic [NUM_WIN-1:0] busy;
   logic [TW-1:0]      lens [NUM_WIN];
   logic               any_trig;
   logic               quals_ok;
   gate_state_t        state;
   gate_reason_t       rsn;

   assign trig[WIN_PACE]  = pace_evt;
   assign trig[WIN_SHOCK] = shock_evt;
   assign trig[WIN_SURG]  = surg_evt;
   assign lens[WIN_PACE]  = pace_len;
   assign lens[WIN_SHOCK] = shock_len;
   assign lens[WIN_SURG]  = surg_len;
   assign any_trig = |trig;
   assign quals_ok = !ovl_flag && noise_ok && thresh_ok;

   generate
      for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
         blank_timer #(
            .TW          (TW),
            .HOLD_ON_OVL (i == WIN_SHOCK && SHOCK_STRETCH)
         ) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .trig   (trig[i]),
            .freeze (ovl_flag),
            .len    (lens[i]),
            .busy   (busy[i])
         );
      end
   endgenerate

   gate_fsm #(.TW(TW)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .any_trig   (any_trig),
      .blank_busy (|busy),
      .quals_ok   (quals_ok),
      .min_hold   (min_hold),
      .state      (state)
   );

   assign det_allowed = (state == ST_ARMED) && quals_ok && !lock_inhibit && !any_trig;

   always_comb begin
      if (lock_inhibit)                          rsn = RSN_LOCK;
      else if (busy[WIN_SHOCK])                  rsn = RSN_SHOCK;
      else if (busy[WIN_PACE])                   rsn = RSN_PACE;
      else if (busy[WIN_SURG])                   rsn = RSN_SURG;
      else if (state == ST_ARMED && quals_ok)    rsn = RSN_OK;
      else if (!ovl_flag && noise_ok && !thresh_ok) rsn = RSN_THRESH;
      else                                       rsn = RSN_RECOV;
   end
   assign reason = rsn;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         det_qual    <= 1'b0;
         mark_stb    <= 1'b0;
         mark_reason <= RSN_RECOV;
         supp_cnt    <= '0;
      end else begin
         det_qual <= raw_det & det_allowed;
         mark_stb <= raw_det;
         if (raw_det) mark_reason <= rsn;
         if (raw_det && !det_allowed && supp_cnt != CNT_MAX)
            supp_cnt <= supp_cnt + 1'b1;
      end
   end

   // No acceptance while any blanking timer runs (R4)
   assert_no_blank_when_allowed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      det_allowed |-> (busy == '0));

   // A qualified strobe needs a raw detect one cycle earlier (R11)
   assert_qual_needs_raw_R11: assert property (@(posedge clk) disable iff (!rst_n)
      det_qual |-> $past(raw_det));

   // Interlock veto blocks qualified strobes (R10)
   assert_lock_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lock_inhibit) |-> !det_qual);

   // Every raw detect leaves a mark (R12)
   assert_mark_follows_raw_R12: assert property (@(posedge clk) disable iff (!rst_n)
      raw_det |=> mark_stb);

   // The suppressed count never goes down (R13)
   assert_supp_no_drop_R13: assert property (@(posedge clk) disable iff (!rst_n)
      supp_cnt >= $past(supp_cnt));

endmodule

// File: tb/sync_blank_gate_test.sv
module sync_blank_gate_test;

   localparam int TW = 8;
   localparam int CW = 8;
   localparam int LP = 6;
   localparam int LS = 10;
   localparam int LE = 4;
   localparam int H  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pace_evt = 0, shock_evt = 0, surg_evt = 0;
   logic ovl_flag = 1, noise_ok = 1, thresh_ok = 1, lock_inhibit = 0, raw_det = 0;
   logic [TW-1:0] pace_len = TW'(LP), shock_len = TW'(LS), surg_len = TW'(LE), min_hold = TW'(H);
   logic det_allowed, det_qual, mark_stb;
   logic [2:0] reason, mark_reason;
   logic [CW-1:0] supp_cnt;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 0;

   typedef struct { logic qual; logic [2:0] rsn; } exp_t;
   exp_t sb[$];

   always #4 clk = ~clk;

   sync_blank_gate #(.TW(TW), .CW(CW), .SHOCK_STRETCH(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .pace_evt(pace_evt), .shock_evt(shock_evt),
      .surg_evt(surg_evt), .ovl_flag(ovl_flag), .noise_ok(noise_ok),
      .thresh_ok(thresh_ok), .lock_inhibit(lock_inhibit), .raw_det(raw_det),
      .pace_len(pace_len), .shock_len(shock_len), .surg_len(surg_len),
      .min_hold(min_hold), .det_allowed(det_allowed), .det_qual(det_qual),
      .reason(reason), .mark_stb(mark_stb), .mark_reason(mark_reason),
      .supp_cnt(supp_cnt)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Driver: one raw detect, expected mark pushed to the scoreboard
   task automatic fire_det(input logic exp_qual, input logic [2:0] exp_rsn);
      @(negedge clk);
      raw_det = 1'b1;
      sb.push_back('{qual: exp_qual, rsn: exp_rsn});
      @(negedge clk);
      raw_det = 1'b0;
   endtask

   // Monitor: compares marks against the scoreboard
   always @(negedge clk) begin
      if (rst_n && mark_stb) begin
         if (sb.size() == 0) begin
            chk(0, "R12 unexpected mark", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(det_qual == e.qual, "R11 det_qual", int'(det_qual), int'(e.qual));
            chk(mark_reason == e.rsn, "R12 mark_reason", int'(mark_reason), int'(e.rsn));
         end
      end
   end

   // Pulse triggers, then count falling edges until det_allowed
   task automatic trig_measure(input bit p, input bit s, input bit e, input int ovl_cyc,
                               input int retrig_at, output int n, output logic [2:0] r1);
      @(negedge clk);
      pace_evt = p; shock_evt = s; surg_evt = e;
      if (ovl_cyc > 0) ovl_flag = 1'b1;
      n = 0;
      r1 = '0;
      do begin
         @(negedge clk);
         n++;
         pace_evt = 0; shock_evt = 0; surg_evt = 0;
         if (n == ovl_cyc) ovl_flag = 1'b0;
         if (n == retrig_at) pace_evt = 1'b1;
         if (n == 1) r1 = reason;
      end while (!det_allowed && n < 500);
   endtask

   task automatic wait_allowed(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!det_allowed && n < 500);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         chk(0, "watchdog", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int n;
      logic [2:0] r1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(det_allowed == 0, "R1 allowed after reset", int'(det_allowed), 0);
      chk(reason == 3'd4, "R1 reason after reset", int'(reason), 4);
      // R13 suppressed detect while recovering
      fire_det(1'b0, 3'd4);
      @(negedge clk);
      chk(supp_cnt == 1, "R13 supp count", int'(supp_cnt), 1);
      // R5 only threshold bad
      ovl_flag = 0; thresh_ok = 0;
      repeat (10) @(negedge clk);
      chk(reason == 3'd5, "R5 thresh reason", int'(reason), 5);
      chk(det_allowed == 0, "R5 held in recovery", int'(det_allowed), 0);
      // R3 holdoff after qualifiers recover
      thresh_ok = 1;
      wait_allowed(n);
      chk(n == H + 2, "R3 re-arm time", n, H + 2);
      // R11 accepted detect
      fire_det(1'b1, 3'd0);
      @(negedge clk);
      chk(supp_cnt == 1, "R11 supp unchanged", int'(supp_cnt), 1);
      // R2 pacing window
      trig_measure(1, 0, 0, 0, 0, n, r1);
      chk(r1 == 3'd1, "R7 pace reason", int'(r1), 1);
      chk(n == LP + H + 4, "R2 pace window", n, LP + H + 4);
      // R6 shock window stretched by overload
      trig_measure(0, 1, 0, 6, 0, n, r1);
      chk(r1 == 3'd2, "R7 shock reason", int'(r1), 2);
      chk(n == LS + 5 + H + 4, "R6 shock stretch", n, LS + 5 + H + 4);
      // pacing with same overload burst is not stretched (R6)
      trig_measure(1, 0, 0, 3, 0, n, r1);
      chk(n == LP + H + 4, "R6 pace not stretched", n, LP + H + 4);
      // R2 electrosurgery window
      trig_measure(0, 0, 1, 0, 0, n, r1);
      chk(r1 == 3'd3, "R7 surg reason", int'(r1), 3);
      chk(n == LE + H + 4, "R2 surg window", n, LE + H + 4);
      // R7 priority
      trig_measure(1, 1, 1, 0, 0, n, r1);
      chk(r1 == 3'd2, "R7 priority shock", int'(r1), 2);
      trig_measure(1, 0, 1, 0, 0, n, r1);
      chk(r1 == 3'd1, "R7 priority pace over surg", int'(r1), 1);
      // R8 retrigger restarts window
      trig_measure(1, 0, 0, 0, 3, n, r1);
      chk(n == 3 + LP + H + 4, "R8 retrigger", n, 3 + LP + H + 4);
      // R9 qualifier loss while armed
      @(negedge clk);
      noise_ok = 0;
      #1;
      chk(det_allowed == 0, "R9 immediate drop", int'(det_allowed), 0);
      chk(reason == 3'd4, "R9 reason", int'(reason), 4);
      @(negedge clk);
      noise_ok = 1;
      wait_allowed(n);
      chk(n == H + 2, "R9 re-arm again", n, H + 2);
      // R10 interlock veto
      @(negedge clk);
      lock_inhibit = 1;
      #1;
      chk(det_allowed == 0, "R10 lock drops allowed", int'(det_allowed), 0);
      chk(reason == 3'd6, "R10 lock reason", int'(reason), 6);
      fire_det(1'b0, 3'd6);
      @(negedge clk);
      chk(supp_cnt == 2, "R13 supp under lock", int'(supp_cnt), 2);
      @(negedge clk);
      pace_evt = 1;
      @(negedge clk);
      pace_evt = 0;
      chk(reason == 3'd6, "R10 lock over blank", int'(reason), 6);
      repeat (LP + H + 6) @(negedge clk);
      // R13 saturation
      for (int i = 0; i < 260; i++) fire_det(1'b0, 3'd6);
      @(negedge clk);
      chk(supp_cnt == 8'd255, "R13 saturate", int'(supp_cnt), 255);
      lock_inhibit = 0;
      #1;
      chk(det_allowed == 1, "R10 release restores", int'(det_allowed), 1);
      repeat (3) @(negedge clk);
      chk(sb.size() == 0, "R12 all marks seen", sb.size(), 0);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule